// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block chooses which interrupt a small processor core takes next. It has three kinds of request. The first is a non-maskable request. The second is one normal source that a configuration input may raise to high priority. The rest are normal-priority sources, each with a pending flag and an enable bit. The core reports instruction boundaries, and arbitration happens only at those points. The block then presents a vector index and holds it until the core acknowledges it. When the core returns from a handler, it pulses a return input.

Acknowledging a request clears an internal global enable. A return sets the global enable again. After a return, one main-line instruction must complete before the next offer. Normal sources are chosen either by fixed index order or by a rotating order that starts just after the normal source serviced most recently. The block keeps an active bit for each of three levels: non-maskable, high and normal. It uses these bits to decide which nesting is allowed.

The controller has three states. IDLE arbitrates at each boundary. OFFER presents the vector and waits for acknowledge. RESUME waits out one boundary after a return. Transitions:

- IDLE→OFFER: at a boundary when some request is eligible.
- OFFER→IDLE: on acknowledge.
- IDLE/RESUME→RESUME: on return.
- RESUME→IDLE: at the first boundary.

Top module: `irq_vec_arb`

## Requirements
- R1: After reset, no request is offered, no level is active and the global enable is clear.
- R2: A request is offered only in the cycle after an instruction boundary seen in IDLE. Once offered, the vector stays constant and the request stays high until acknowledge, whatever the source inputs do. The request drops in the cycle after acknowledge.
- R3: Vector 0 means the non-maskable source. Normal source `i` (bit `i` of `src_pend`/`src_en`) is reported as vector `i+1`.
- R4: In fixed mode (`rr_mode`=0), the lowest-indexed source with both pending and enable set wins. A source whose enable is 0 is never offered.
- R5: In rotating mode (`rr_mode`=1), the search begins at the source after the normal source acknowledged most recently, wrapping from the top index to 0. High-level and non-maskable acknowledges leave this starting point unchanged.
- R6: The non-maskable request wins over every other request and ignores the global enable. It is taken even while a normal or high handler is active, but not while a non-maskable handler is active.
- R7: When `hi_valid`=1, source `hi_sel` is a high-level source. It beats all normal sources. It may be taken while a normal handler is active, even though that acknowledge cleared the global enable.
- R8: A normal-level request is never offered while any handler (normal, high or non-maskable) is active, even with the global enable set.
- R9: Acknowledge clears the global enable. While the global enable is clear, no normal request is offered. `gie_clr` clears the global enable and `gie_set` sets it.
- R10: A return clears only the highest active level and sets the global enable. The first boundary after a return produces no offer; the next boundary may.
- R11: In fixed mode, a low-indexed source that stays pending is offered again after every return. Higher-indexed sources are never offered meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pend | input | NUM_SRC | Pending flags of the normal sources |
| src_en | input | NUM_SRC | Per-source enables |
| nmi_req | input | 1 | Non-maskable request |
| gie_set | input | 1 | Core sets the global enable |
| gie_clr | input | 1 | Core clears the global enable |
| rr_mode | input | 1 | 1 = rotating order, 0 = fixed order |
| hi_valid | input | 1 | A source is promoted to high level |
| hi_sel | input | SRC_W | Index of the promoted source |
| insn_bound | input | 1 | Core is at an instruction boundary |
| irq_ack | input | 1 | Core accepts the offered vector |
| irq_reti | input | 1 | Core returns from a handler |
| irq_req | output | 1 | A vector is offered |
| irq_vec | output | VEC_W | Offered vector index |

## Verification
The assertions assume that the core pulses `irq_ack` only while `irq_req` is high. They also assume that `irq_reti` never arrives during an offer, because a return in OFFER would clear an active bit without leaving the state. The stimulus follows both rules. Every acknowledge and return is issued only after the bench has seen the matching offer or the end of the offer. Each return is paired with a handler the bench has previously acknowledged, so the active levels never underflow.

// File: rtl/ivarb_pkg.sv
package ivarb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OFFER  = 2'd1,
        ST_RESUME = 2'd2
    } arb_state_e;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_NORM = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_NMI  = 2'd3
    } lvl_e;
endpackage

// File: rtl/ivarb_pick.sv
module ivarb_pick #(
    parameter int NUM_SRC = 8,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic [SRC_W-1:0]   start,
    output logic               hit,
    output logic [SRC_W-1:0]   idx
);
    // Search upward from start, wrapping past the top index.
    always_comb begin
        int j;
        hit = 1'b0;
        idx = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            j = int'(start) + k;
            if (j >= NUM_SRC) j = j - NUM_SRC;
            if (!hit && req[j]) begin
                hit = 1'b1;
                idx = SRC_W'(j);
            end
        end
    end
endmodule

// File: rtl/ivarb_cand.sv
module ivarb_cand
    import ivarb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int VEC_W  = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0] src_pend,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               nmi_req,
    input  logic               hi_valid,
    input  logic [SRC_W-1:0]   hi_sel,
    input  logic               rr_mode,
    input  logic [SRC_W-1:0]   rr_ptr,
    input  logic               gie,
    input  logic               nmi_act,
    input  logic               hi_act,
    input  logic               nrm_act,
    output logic               cand_valid,
    output logic [VEC_W-1:0]   cand_vec,
    output logic [SRC_W-1:0]   cand_src,
    output lvl_e               cand_lvl
);
    logic [NUM_SRC-1:0] hi_mask;
    logic [NUM_SRC-1:0] live;
    logic [NUM_SRC-1:0] norm_pool;
    logic               hi_hit;
    logic               p_hit;
    logic [SRC_W-1:0]   p_idx;
    logic [SRC_W-1:0]   p_start;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_hmask
        assign hi_mask[g] = hi_valid && (hi_sel == SRC_W'(g));
    end

    assign live      = src_pend & src_en;
    assign norm_pool = live & ~hi_mask;
    assign hi_hit    = |(live & hi_mask);
    assign p_start   = rr_mode ? rr_ptr : '0;

    ivarb_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .req   (norm_pool),
        .start (p_start),
        .hit   (p_hit),
        .idx   (p_idx)
    );

    always_comb begin
        cand_valid = 1'b0;
        cand_vec   = '0;
        cand_src   = '0;
        cand_lvl   = LVL_NONE;
        if (nmi_req && !nmi_act) begin
            cand_valid = 1'b1;
            cand_lvl   = LVL_NMI;
        end else if (hi_hit && !nmi_act && !hi_act && (gie || nrm_act)) begin
            cand_valid = 1'b1;
            cand_vec   = VEC_W'(hi_sel) + VEC_W'(1);
            cand_src   = hi_sel;
            cand_lvl   = LVL_HIGH;
        end else if (p_hit && gie && !nmi_act && !hi_act && !nrm_act) begin
            cand_valid = 1'b1;
            cand_vec   = VEC_W'(p_idx) + VEC_W'(1);
            cand_src   = p_idx;
            cand_lvl   = LVL_NORM;
        end
    end
endmodule

// File: rtl/ivarb_levels.sv
module ivarb_levels
    import ivarb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  lvl_e take_lvl,
    input  logic reti,
    input  logic gie_set,
    input  logic gie_clr,
    output logic gie,
    output logic nmi_act,
    output logic hi_act,
    output logic nrm_act
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie     <= 1'b0;
            nmi_act <= 1'b0;
            hi_act  <= 1'b0;
            nrm_act <= 1'b0;
        end else begin
            if (take)         gie <= 1'b0;
            else if (reti)    gie <= 1'b1;
            else if (gie_clr) gie <= 1'b0;
            else if (gie_set) gie <= 1'b1;

            if (take) begin
                case (take_lvl)
                    LVL_NMI:  nmi_act <= 1'b1;
                    LVL_HIGH: hi_act  <= 1'b1;
                    LVL_NORM: nrm_act <= 1'b1;
                    default:  ;
                endcase
            end else if (reti) begin
                if (nmi_act)     nmi_act <= 1'b0;
                else if (hi_act) hi_act  <= 1'b0;
                else             nrm_act <= 1'b0;
            end
        end
    end

    AST_NORM_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_lvl == LVL_NORM) |-> !(nmi_act || hi_act || nrm_act)); // R8

    AST_RETI_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !take && (nmi_act || hi_act || nrm_act)) |=>
        ($countones({nmi_act, hi_act, nrm_act}) ==
         $countones($past({nmi_act, hi_act, nrm_act})) - 1)); // R10
endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb
    import ivarb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int VEC_W  = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pend,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               nmi_req,
    input  logic               gie_set,
    input  logic               gie_clr,
    input  logic               rr_mode,
    input  logic               hi_valid,
    input  logic [SRC_W-1:0]   hi_sel,
    input  logic               insn_bound,
    input  logic               irq_ack,
    input  logic               irq_reti,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec
);
    arb_state_e       state, state_nx;
    logic             gie, nmi_act, hi_act, nrm_act;
    logic             cand_valid;
    logic [VEC_W-1:0] cand_vec;
    logic [SRC_W-1:0] cand_src;
    lvl_e             cand_lvl;
    logic [VEC_W-1:0] off_vec;
    logic [SRC_W-1:0] off_src;
    lvl_e             off_lvl;
    logic [SRC_W-1:0] rr_ptr;
    logic             take;
    logic             latch;

    assign take  = (state == ST_OFFER) && irq_ack;
    assign latch = (state == ST_IDLE) && !irq_reti && insn_bound && cand_valid;

    ivarb_cand #(.NUM_SRC(NUM_SRC)) u_cand (
        .src_pend   (src_pend),
        .src_en     (src_en),
        .nmi_req    (nmi_req),
        .hi_valid   (hi_valid),
        .hi_sel     (hi_sel),
        .rr_mode    (rr_mode),
        .rr_ptr     (rr_ptr),
        .gie        (gie),
        .nmi_act    (nmi_act),
        .hi_act     (hi_act),
        .nrm_act    (nrm_act),
        .cand_valid (cand_valid),
        .cand_vec   (cand_vec),
        .cand_src   (cand_src),
        .cand_lvl   (cand_lvl)
    );

    ivarb_levels u_levels (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .take_lvl (off_lvl),
        .reti     (irq_reti),
        .gie_set  (gie_set),
        .gie_clr  (gie_clr),
        .gie      (gie),
        .nmi_act  (nmi_act),
        .hi_act   (hi_act),
        .nrm_act  (nrm_act)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (irq_reti)  state_nx = ST_RESUME;
                else if (latch) state_nx = ST_OFFER;
            end
            ST_OFFER: begin
                if (irq_ack) state_nx = ST_IDLE;
            end
            ST_RESUME: begin
                if (irq_reti)        state_nx = ST_RESUME;
                else if (insn_bound) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // offered vector and rotation pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_vec <= '0;
            off_src <= '0;
            off_lvl <= LVL_NONE;
            rr_ptr  <= '0;
        end else begin
            if (latch) begin
                off_vec <= cand_vec;
                off_src <= cand_src;
                off_lvl <= cand_lvl;
            end
            if (take && off_lvl == LVL_NORM) begin
                rr_ptr <= (off_src == SRC_W'(NUM_SRC - 1)) ? '0 : off_src + SRC_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        irq_req = (state == ST_OFFER);
        irq_vec = off_vec;
    end

    AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec))); // R2

    AST_OFFER_AT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(insn_bound)); // R2

    AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_req) && $past(nmi_req) && !$past(nmi_act)) |-> (irq_vec == '0)); // R6

    AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> (!gie && !irq_req)); // R9

    AST_RETI_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_reti && !irq_req) |=> !irq_req); // R10
endmodule

// File: tb/irq_vec_arb_tb_top.sv
`timescale 1ns/1ps
module irq_vec_arb_tb_top;
    localparam int N    = 8;
    localparam int SW   = $clog2(N);
    localparam int VW   = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_pend = '0;
    logic [N-1:0]  src_en = '1;
    logic          nmi_req = 1'b0;
    logic          gie_set = 1'b0;
    logic          gie_clr = 1'b0;
    logic          rr_mode = 1'b0;
    logic          hi_valid = 1'b0;
    logic [SW-1:0] hi_sel = '0;
    logic          insn_bound = 1'b0;
    logic          irq_ack = 1'b0;
    logic          irq_reti = 1'b0;
    logic          irq_req;
    logic [VW-1:0] irq_vec;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles = 0;
    string cur_tag = "R1";

    always #4 clk = ~clk;

    irq_vec_arb #(.NUM_SRC(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_en(src_en),
        .nmi_req(nmi_req), .gie_set(gie_set), .gie_clr(gie_clr),
        .rr_mode(rr_mode), .hi_valid(hi_valid), .hi_sel(hi_sel),
        .insn_bound(insn_bound), .irq_ack(irq_ack), .irq_reti(irq_reti),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );

    // behavioural reference: mode 0 idle, 1 offering, 2 waiting after return
    int m_mode, m_gie, m_nmi, m_hi, m_nrm, m_rr, m_vec, m_lvl;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_gie = 0; m_nmi = 0; m_hi = 0; m_nrm = 0;
            m_rr = 0; m_vec = 0; m_lvl = 0;
        end else begin
            int cv, cl, s, hs;
            int took;
            cv = -1; cl = 0;
            hs = hi_valid ? int'(hi_sel) : -1;
            if (nmi_req && m_nmi == 0) begin
                cv = 0; cl = 3;
            end else if (hs >= 0 && src_pend[hs] && src_en[hs] && m_nmi == 0 &&
                         m_hi == 0 && (m_gie == 1 || m_nrm == 1)) begin
                cv = hs + 1; cl = 2;
            end else if (m_gie == 1 && m_nmi == 0 && m_hi == 0 && m_nrm == 0) begin
                for (int k = 0; k < N; k++) begin
                    s = ((rr_mode ? m_rr : 0) + k) % N;
                    if (cv < 0 && s != hs && src_pend[s] && src_en[s]) begin
                        cv = s + 1; cl = 1;
                    end
                end
            end
            took = (m_mode == 1 && irq_ack) ? 1 : 0;
            if (took == 1) begin
                m_gie = 0;
                if (m_lvl == 3) m_nmi = 1;
                if (m_lvl == 2) m_hi = 1;
                if (m_lvl == 1) begin
                    m_nrm = 1;
                    m_rr = m_vec % N;
                end
            end else if (irq_reti) begin
                m_gie = 1;
                if (m_nmi == 1) m_nmi = 0;
                else if (m_hi == 1) m_hi = 0;
                else m_nrm = 0;
            end else if (gie_clr) m_gie = 0;
            else if (gie_set) m_gie = 1;

            if (m_mode == 1) begin
                if (irq_ack) m_mode = 0;
            end else if (irq_reti) begin
                m_mode = 2;
            end else if (m_mode == 2) begin
                if (insn_bound) m_mode = 0;
            end else if (insn_bound && cv >= 0) begin
                m_mode = 1; m_vec = cv; m_lvl = cl;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_tag, int'(irq_req), (m_mode == 1) ? 1 : 0);
            if (m_mode == 1) check(cur_tag, int'(irq_vec), m_vec);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic bound();
        insn_bound = 1'b1; @(negedge clk); insn_bound = 1'b0;
    endtask
    task automatic ack();
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    endtask
    task automatic reti();
        irq_reti = 1'b1; @(negedge clk); irq_reti = 1'b0;
    endtask
    task automatic pulse_set();
        gie_set = 1'b1; @(negedge clk); gie_set = 1'b0;
    endtask

    task automatic serve(input int exp_vec, input string tag);
        bound();
        check(tag, int'(irq_req), 1);
        check(tag, int'(irq_vec), exp_vec);
        ack();
        check("R2", int'(irq_req), 0);
        reti();
        bound();
        check("R10", int'(irq_req), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(irq_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        cur_tag = "R9";
        src_pend = 8'b0000_0100;
        bound();
        check("R9", int'(irq_req), 0);
        pulse_set();

        cur_tag = "R4";
        src_pend = 8'b0010_0100;
        bound();
        check("R3", int'(irq_req), 1);
        check("R4", int'(irq_vec), 3);

        cur_tag = "R2";
        src_pend = 8'b0010_0000;
        repeat (3) @(negedge clk);
        check("R2", int'(irq_req), 1);
        check("R2", int'(irq_vec), 3);
        ack();
        check("R2", int'(irq_req), 0);

        cur_tag = "R9";
        bound();
        check("R9", int'(irq_req), 0);
        cur_tag = "R8";
        pulse_set();
        bound();
        check("R8", int'(irq_req), 0);

        cur_tag = "R6";
        nmi_req = 1'b1;
        bound();
        check("R6", int'(irq_req), 1);
        check("R6", int'(irq_vec), 0);
        ack();
        bound();
        check("R6", int'(irq_req), 0);
        nmi_req = 1'b0;
        cur_tag = "R10";
        reti();
        bound();
        check("R10", int'(irq_req), 0);

        cur_tag = "R7";
        hi_valid = 1'b1;
        hi_sel = 3'd4;
        src_pend = 8'b0001_0000;
        bound();
        check("R7", int'(irq_req), 1);
        check("R7", int'(irq_vec), 5);
        ack();
        reti();
        bound();
        reti();
        bound();
        src_pend = 8'b0001_0010;
        serve(5, "R7");
        hi_valid = 1'b0;

        cur_tag = "R11";
        src_pend = 8'b0100_0010;
        for (int i = 0; i < 3; i++) serve(2, "R11");

        cur_tag = "R4";
        src_en = 8'b1111_1110;
        src_pend = 8'b0000_0101;
        serve(3, "R4");
        src_en = '1;

        cur_tag = "R5";
        rr_mode = 1'b1;
        src_pend = 8'b0100_1010;
        serve(4, "R5");
        serve(7, "R5");
        serve(2, "R5");
        serve(4, "R5");
        rr_mode = 1'b0;

        cur_tag = "R9";
        gie_clr = 1'b1; @(negedge clk); gie_clr = 1'b0;
        src_pend = 8'b0000_0010;
        bound();
        check("R9", int'(irq_req), 0);
        cur_tag = "R6";
        nmi_req = 1'b1;
        bound();
        check("R6", int'(irq_vec), 0);
        check("R6", int'(irq_req), 1);
        ack();
        nmi_req = 1'b0;
        reti();
        bound();
        serve(2, "R10");

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule